// File: doc/BRIEF.md
# CSR Value Consistency Monitor

This block watches the trace of a single control/status register: one observation stream carries values read from the register and another carries values written to it. It keeps a shadow copy of the last value that matters for the selected rule and judges every new read against it. The rule is fixed at elaboration. It can be one of the following: exact readback of written data, a non-decreasing value, a strictly increasing counter that must never be written, a fixed constant, or all zeros. In constant mode the reference can instead be the first value read after reset. Violations raise a one-cycle error pulse and a sticky error flag.

A separate cover pulse fires whenever a read is strictly greater than the shadow. A bench can use it to show that increases actually occur. Both observation inputs are valid-only streams. The monitor accepts a beat on every cycle and never applies back-pressure, so there is no ready signal. A read beat and a write beat may arrive in the same cycle. In that case the read is judged first and the write is applied afterwards. All outputs are registered, and each one reflects the observation from the previous cycle. Only one channel is tracked.

Top module: `csr_consistency_monitor`

## Requirements
- R1: While reset is low and in the first cycle after it, err_pulse, err_sticky, illegal_write and incr_cover are all 0, and the shadow is empty.
- R2: In the modes that compare against a shadow, the first observation after reset only fills the shadow and never raises err_pulse.
- R3: In readback mode (MON_READBACK), a read whose masked value differs from the masked value of the last observation (read or write) is a violation. When a read and a write arrive in the same cycle, the read is checked first and the write value then becomes the shadow.
- R4: In non-decreasing mode (MON_NONDEC), a read below the shadow is a violation. A write reloads the shadow without any check, so a decrease is allowed only through a write. An observation whose most significant bit is 1 is neither checked nor loaded.
- R5: In up-counter mode (MON_UPCOUNT), a read that is less than or equal to the previous read is a violation.
- R6: In up-counter mode, a write sets illegal_write one cycle later. The flag stays set until reset. A write does not load the shadow and does not pulse err_pulse. illegal_write stays 0 in every other mode.
- R7: In constant mode (MON_CONST), each read is compared under the mask with CONST_VAL, and writes are ignored. When CONST_FROM_SHADOW is 1, the first read after reset becomes the reference instead of CONST_VAL.
- R8: In zero mode (MON_ZERO), each read must be zero in every bit that is set in MASK. Writes are ignored.
- R9: err_pulse is 1 for exactly the cycle after a violating read. err_sticky rises at the same time and stays 1 until reset.
- R10: incr_cover is 1 for one cycle after a read whose full value is strictly greater than a valid shadow. In the fixed-reference modes there is no shadow, so incr_cover never fires there.
- R11: MASK applies to the readback, constant and zero comparisons. The ordering comparisons and the cover comparison use the full value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | A read of the register is observed this cycle |
| rd_data | input | W | Value returned by the read |
| wr_valid | input | 1 | A write to the register is observed this cycle |
| wr_data | input | W | Value written |
| err_pulse | output | 1 | One-cycle violation indication |
| err_sticky | output | 1 | Violation seen since reset |
| illegal_write | output | 1 | A write was seen in up-counter mode (sticky) |
| incr_cover | output | 1 | The previous read was strictly greater than the shadow |

## Verification
The assertions check properties on every cycle. Once raised, the sticky flags hold. A pulse always comes with the sticky flag. The first observation into an empty shadow is never flagged. A write in up-counter mode is always followed by illegal_write. In the ordering modes, a read never counts as both a violation and an increase. Whether the right reads are flagged depends on the values involved, and only the bench scenarios can show that: mask-hidden differences, same-cycle read and write ordering, skipping of values with the top bit set, and repeated counter values.

// File: rtl/csr_mon_pkg.sv
package csr_mon_pkg;
  typedef enum logic [2:0] {
    MON_READBACK = 3'd0,
    MON_NONDEC   = 3'd1,
    MON_UPCOUNT  = 3'd2,
    MON_CONST    = 3'd3,
    MON_ZERO     = 3'd4
  } mon_mode_e;
endpackage

// File: rtl/csr_mon_shadow.sv
module csr_mon_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         shv,
  output logic [W-1:0] sh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shv <= 1'b0;
      sh  <= '0;
    end else if (load) begin
      shv <= 1'b1;
      sh  <= load_val;
    end
  end
endmodule

// File: rtl/csr_mon_judge.sv
module csr_mon_judge
  import csr_mon_pkg::*;
#(
  parameter int           W         = 32,
  parameter mon_mode_e    MODE      = MON_READBACK,
  parameter logic [W-1:0] MASK      = '1,
  parameter logic [W-1:0] REF_VAL   = '0,
  parameter bit           REF_SHDW  = 1'b0
) (
  input  logic         rd_valid,
  input  logic [W-1:0] rd_data,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         shv,
  input  logic [W-1:0] sh,
  output logic         viol,
  output logic         cov,
  output logic         illw,
  output logic         load,
  output logic [W-1:0] load_val
);
  logic unused_sink;
  assign unused_sink = ^{rd_valid, rd_data, wr_valid, wr_data, shv, sh};

  generate
    if (MODE == MON_READBACK) begin : g_readback
      always_comb begin
        viol     = rd_valid && shv && (((rd_data ^ sh) & MASK) != '0);
        cov      = rd_valid && shv && (rd_data > sh);
        illw     = 1'b0;
        load     = rd_valid || wr_valid;
        load_val = wr_valid ? wr_data : rd_data;
      end
    end else if (MODE == MON_NONDEC) begin : g_nondec
      logic rd_ok, wr_ok;
      always_comb begin
        rd_ok    = rd_valid && !rd_data[W-1];
        wr_ok    = wr_valid && !wr_data[W-1];
        viol     = rd_ok && shv && (rd_data < sh);
        cov      = rd_ok && shv && (rd_data > sh);
        illw     = 1'b0;
        load     = rd_ok || wr_ok;
        load_val = wr_ok ? wr_data : rd_data;
      end
    end else if (MODE == MON_UPCOUNT) begin : g_upcount
      always_comb begin
        viol     = rd_valid && shv && (rd_data <= sh);
        cov      = rd_valid && shv && (rd_data > sh);
        illw     = wr_valid;
        load     = rd_valid;
        load_val = rd_data;
      end
    end else if (REF_SHDW) begin : g_const_shadow
      always_comb begin
        viol     = rd_valid && shv && (((rd_data ^ sh) & MASK) != '0);
        cov      = rd_valid && shv && (rd_data > sh);
        illw     = 1'b0;
        load     = rd_valid && !shv;
        load_val = rd_data;
      end
    end else begin : g_const_fixed
      always_comb begin
        viol     = rd_valid && (((rd_data ^ REF_VAL) & MASK) != '0);
        cov      = 1'b0;
        illw     = 1'b0;
        load     = 1'b0;
        load_val = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/csr_mon_report.sv
module csr_mon_report (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  input  logic cov,
  input  logic illw,
  output logic err_pulse,
  output logic err_sticky,
  output logic illegal_write,
  output logic incr_cover
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse     <= 1'b0;
      err_sticky    <= 1'b0;
      illegal_write <= 1'b0;
      incr_cover    <= 1'b0;
    end else begin
      err_pulse     <= viol;
      err_sticky    <= err_sticky | viol;
      illegal_write <= illegal_write | illw;
      incr_cover    <= cov;
    end
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  // R9
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);
  // R6
  illw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_write |=> illegal_write);
endmodule

// File: rtl/csr_consistency_monitor.sv
module csr_consistency_monitor
  import csr_mon_pkg::*;
#(
  parameter int           W                 = 32,
  parameter mon_mode_e    MODE              = MON_READBACK,
  parameter logic [W-1:0] MASK              = '1,
  parameter logic [W-1:0] CONST_VAL         = '0,
  parameter bit           CONST_FROM_SHADOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_valid,
  input  logic [W-1:0] rd_data,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         err_pulse,
  output logic         err_sticky,
  output logic         illegal_write,
  output logic         incr_cover
);
  localparam logic [W-1:0] REF_VAL  = (MODE == MON_ZERO) ? '0 : CONST_VAL;
  localparam bit           REF_SHDW = (MODE == MON_CONST) && CONST_FROM_SHADOW;
  localparam bit           ORDERED  = (MODE == MON_NONDEC) || (MODE == MON_UPCOUNT);
  localparam bit           SHADOWED = (MODE == MON_READBACK) || ORDERED || REF_SHDW;

  logic         shv;
  logic [W-1:0] sh;
  logic         viol, cov, illw, load;
  logic [W-1:0] load_val;

  csr_mon_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .shv(shv), .sh(sh)
  );

  csr_mon_judge #(
    .W(W), .MODE(MODE), .MASK(MASK), .REF_VAL(REF_VAL), .REF_SHDW(REF_SHDW)
  ) u_judge (
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .shv(shv), .sh(sh),
    .viol(viol), .cov(cov), .illw(illw), .load(load), .load_val(load_val)
  );

  csr_mon_report u_report (
    .clk(clk), .rst_n(rst_n), .viol(viol), .cov(cov), .illw(illw),
    .err_pulse(err_pulse), .err_sticky(err_sticky),
    .illegal_write(illegal_write), .incr_cover(incr_cover)
  );

  generate
    if (SHADOWED) begin : g_first_obs
      // R2
      first_obs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_valid || wr_valid) && !shv) |=> !err_pulse);
    end
    if (MODE == MON_UPCOUNT) begin : g_upc
      // R6
      upc_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> illegal_write);
    end else begin : g_no_upc
      // R6
      no_illw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_write);
    end
    if (ORDERED) begin : g_ordered
      // R10
      cover_vs_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(incr_cover && err_pulse));
    end
  endgenerate
endmodule

// File: tb/tb_csr_consistency_monitor.sv
`timescale 1ns/1ps
module tb_csr_consistency_monitor;
  import csr_mon_pkg::*;
  localparam int W = 16;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rv = 1'b0, wv = 1'b0;
  logic [W-1:0] rd = '0, wd = '0;
  always #2.5 clk = ~clk;

  logic [3:0] got [N];

  csr_consistency_monitor #(.W(W), .MODE(MON_READBACK), .MASK(16'hFF0F)) dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[0][3]), .err_pulse(got[0][2]), .illegal_write(got[0][1]), .incr_cover(got[0][0]));
  csr_consistency_monitor #(.W(W), .MODE(MON_NONDEC)) dut_inc (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[1][3]), .err_pulse(got[1][2]), .illegal_write(got[1][1]), .incr_cover(got[1][0]));
  csr_consistency_monitor #(.W(W), .MODE(MON_UPCOUNT)) dut_upc (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[2][3]), .err_pulse(got[2][2]), .illegal_write(got[2][1]), .incr_cover(got[2][0]));
  csr_consistency_monitor #(.W(W), .MODE(MON_CONST), .MASK(16'hFF00), .CONST_VAL(16'h5A00)) dut_cst (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[3][3]), .err_pulse(got[3][2]), .illegal_write(got[3][1]), .incr_cover(got[3][0]));
  csr_consistency_monitor #(.W(W), .MODE(MON_CONST), .CONST_FROM_SHADOW(1'b1)) dut_shd (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[4][3]), .err_pulse(got[4][2]), .illegal_write(got[4][1]), .incr_cover(got[4][0]));
  csr_consistency_monitor #(.W(W), .MODE(MON_ZERO), .MASK(16'h7FFF)) dut_zero (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_data(rd), .wr_valid(wv), .wr_data(wd),
    .err_sticky(got[5][3]), .err_pulse(got[5][2]), .illegal_write(got[5][1]), .incr_cover(got[5][0]));

  int compared = 0, mismatched = 0;
  logic         m_shv [N];
  logic [W-1:0] m_sh  [N];
  logic [3:0]   m_exp [N];

  function automatic logic [W-1:0] mask_of(int i);
    case (i)
      0: return 16'hFF0F;
      3: return 16'hFF00;
      5: return 16'h7FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0: return "R3 R11 R2 R9 R10";
      1: return "R4 R2 R9 R10";
      2: return "R5 R6 R9 R10";
      3: return "R7 R11 R9";
      4: return "R7 R2 R10";
      default: return "R8 R11 R9";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_shv[i] = 1'b0; m_sh[i] = '0; m_exp[i] = 4'b0000;
    end
  endtask

  // Expected outputs after the next edge, from the requirements.
  task automatic model_step(logic r, logic [W-1:0] rdv, logic w, logic [W-1:0] wdv);
    for (int i = 0; i < N; i++) begin
      logic v, c, il;
      logic [W-1:0] k;
      k = mask_of(i); v = 0; c = 0; il = 0;
      case (i)
        0: begin
          v = r && m_shv[i] && (((rdv ^ m_sh[i]) & k) != 0);
          c = r && m_shv[i] && (rdv > m_sh[i]);
          if (w) begin m_sh[i] = wdv; m_shv[i] = 1; end
          else if (r) begin m_sh[i] = rdv; m_shv[i] = 1; end
        end
        1: begin
          logic ro, wo;
          ro = r && !rdv[W-1]; wo = w && !wdv[W-1];
          v = ro && m_shv[i] && (rdv < m_sh[i]);
          c = ro && m_shv[i] && (rdv > m_sh[i]);
          if (wo) begin m_sh[i] = wdv; m_shv[i] = 1; end
          else if (ro) begin m_sh[i] = rdv; m_shv[i] = 1; end
        end
        2: begin
          v = r && m_shv[i] && (rdv <= m_sh[i]);
          c = r && m_shv[i] && (rdv > m_sh[i]);
          il = w;
          if (r) begin m_sh[i] = rdv; m_shv[i] = 1; end
        end
        3: v = r && (((rdv ^ 16'h5A00) & k) != 0);
        4: begin
          v = r && m_shv[i] && (rdv != m_sh[i]);
          c = r && m_shv[i] && (rdv > m_sh[i]);
          if (r && !m_shv[i]) begin m_sh[i] = rdv; m_shv[i] = 1; end
        end
        default: v = r && ((rdv & k) != 0);
      endcase
      m_exp[i] = {m_exp[i][3] | v, v, m_exp[i][1] | il, c};
    end
  endtask

  task automatic check_all(string extra);
    for (int i = 0; i < N; i++) begin
      compared++;
      if (got[i] !== m_exp[i]) begin
        mismatched++;
        $display("FAIL %s %s inst%0d: got sticky/pulse/illw/cov=%b expected %b",
                 tag_of(i), extra, i, got[i], m_exp[i]);
      end
    end
  endtask

  task automatic cyc(logic r, logic [W-1:0] rdv, logic w, logic [W-1:0] wdv);
    @(negedge clk);
    check_all("");
    rv = r; rd = rdv; wv = w; wd = wdv;
    model_step(r, rdv, w, wdv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_all("");
    rst_n = 0; rv = 0; wv = 0; rd = '0; wd = '0;
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] last, cnt;
    void'($urandom(32'd4242));
    model_reset();
    do_reset();
    // R3 R11 directed readback, R2 first observation
    cyc(0, 0, 1, 16'h1234);
    cyc(1, 16'h1234, 0, 0);
    cyc(1, 16'h12F4, 0, 0);        // differs only in masked-off bits
    cyc(1, 16'h1334, 0, 0);        // masked difference
    cyc(1, 16'h1334, 1, 16'h0042); // read first, then write
    cyc(1, 16'h0042, 0, 0);
    cyc(0, 0, 0, 0);
    // random mix
    last = 16'h0042;
    for (int n = 0; n < 150; n++) begin
      logic r, w;
      logic [W-1:0] a, b;
      r = ($urandom % 2) == 0;
      w = ($urandom % 4) == 0;
      a = (($urandom % 3) != 0) ? last : W'($urandom);
      b = W'($urandom);
      cyc(r, a, w, b);
      if (w) last = b; else if (r) last = a;
    end
    do_reset();
    // R5 R4 R10 counter pattern, writes only in the second half (R6)
    cnt = 16'd10;
    for (int n = 0; n < 120; n++) begin
      logic w;
      w = (n > 60) && (($urandom % 8) == 0);
      cyc(1, cnt, w, cnt - 16'd5);
      if (w) cnt = cnt - 16'd3;
      else cnt = cnt + W'($urandom % 3);
    end
    do_reset();
    // R4 top-bit exclusion, R7 R8 constants
    cyc(1, 16'h9000, 0, 0);
    cyc(1, 16'h0005, 0, 0);
    cyc(1, 16'hF000, 0, 0);
    cyc(1, 16'h0003, 0, 0);
    cyc(0, 0, 1, 16'h8001);
    cyc(1, 16'h0002, 0, 0);
    cyc(1, 16'h5A33, 1, 16'h1111);
    cyc(1, 16'h5B00, 0, 0);
    cyc(1, 16'h8000, 0, 0);
    cyc(0, 0, 0, 0);
    do_reset();
    // R7 R8 random constant-ish reads with writes ignored
    for (int n = 0; n < 100; n++) begin
      logic [W-1:0] a;
      case ($urandom % 4)
        0: a = 16'h5A00 | W'($urandom % 256);
        1: a = 16'h5A00;
        2: a = (($urandom % 2) == 0) ? 16'h0000 : 16'h8000;
        default: a = W'($urandom);
      endcase
      cyc(($urandom % 3) != 0, a, ($urandom % 3) == 0, W'($urandom));
    end
    @(negedge clk);
    check_all("");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule